// File: doc/BRIEF.md
# Isolated Digital I/O Port Controller

This peripheral sits on a simple 8-bit parallel bus with an address, write data, read data, a read strobe and a write strobe. It answers to a window of eight byte addresses starting at a configurable base. It drives sixteen latched output lines, which software writes one byte at a time. It samples sixteen input lines, which software reads back one byte at a time.

The sixteen inputs pass through a synchroniser. A change in either direction on any input can latch a sticky pending flag. The block raises one level-high interrupt request while that flag is set and interrupt generation is enabled. Interrupt control uses access side effects only, with no control register. A read of the control offset enables interrupt generation and a write to it disables generation. A write to the low input-byte offset clears the pending flag. The data value is ignored in both writes.

Top module: `iso_dio_port`

## Requirements
- R1: After reset all sixteen output lines are at logic one (0xFFFF), interrupt generation is disabled, the pending flag is clear and `irq` is low.
- R2: A write to window offset 0 sets output lines 7..0 from the write data, and a write to offset 4 sets lines 15..8; the other byte keeps its value, and the lines change on the clock edge that samples the strobe.
- R3: While `bus_rd` is high, offset 0 returns output lines 7..0 and offset 4 returns output lines 15..8.
- R4: While `bus_rd` is high, offset 1 returns input lines 7..0 and offset 5 returns input lines 15..8, as seen through a two-stage synchroniser (an input change is visible after the second clock edge).
- R5: Reads of offsets 3, 6 and 7 return 0x00, and writes to them change no output line and no interrupt state.
- R6: The window covers byte addresses BASE to BASE+7, with BASE a multiple of 8. An access outside it returns 0x00 and has no effect. `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R7: A read of offset 2 enables interrupt generation from the next clock edge on. If the pending flag is already set, `irq` then goes high.
- R8: A write to offset 2, with any data, disables interrupt generation, and `irq` is low after that clock edge.
- R9: With interrupt generation enabled, a rising or falling change on any input line sets the pending flag, and `irq` goes high after the third clock edge following the input change.
- R10: The pending flag stays set through further input changes until a write to offset 1, with any data, clears it. If a new change is detected in the same cycle as that write, the flag stays set.
- R11: An input change detected while interrupt generation is disabled does not set the pending flag, so enabling afterwards leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (10) | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| in_lines | input | N_IN (16) | Asynchronous input lines |
| out_lines | output | N_OUT (16) | Latched output lines |
| irq | output | 1 | Interrupt request, level high |

## Verification
The case that is hardest to reach is a pending-clear write that lands in the same clock cycle as a newly detected input change. The change becomes visible only two edges after the pin moves, so the clear write must be placed exactly one cycle before the flag would be set. The directed part of the stimulus counts negative edges from the input change and issues the offset-1 write at that point. It also covers an input change while interrupts are disabled, followed by a later enable. The random part mixes byte writes, reads, control accesses and input changes, including addresses outside the window.

// File: rtl/iso_dio_pkg.sv
package iso_dio_pkg;
  localparam int BYTE_W   = 8;
  localparam int WIN_LOG2 = 3;
  localparam int WIN_SIZE = 1 << WIN_LOG2;

  typedef enum logic [WIN_LOG2-1:0] {
    OFS_OUT_LO = 3'd0,
    OFS_IN_LO  = 3'd1,
    OFS_CTRL   = 3'd2,
    OFS_RSV3   = 3'd3,
    OFS_OUT_HI = 3'd4,
    OFS_IN_HI  = 3'd5,
    OFS_RSV6   = 3'd6,
    OFS_RSV7   = 3'd7
  } ofs_e;

  // window offset that carries output byte b / input byte b
  function automatic int unsigned out_ofs(input int unsigned b);
    return (b == 0) ? 32'(OFS_OUT_LO) : 32'(OFS_OUT_HI);
  endfunction

  function automatic int unsigned in_ofs(input int unsigned b);
    return (b == 0) ? 32'(OFS_IN_LO) : 32'(OFS_IN_HI);
  endfunction
endpackage

// File: rtl/iso_dio_decode.sv
module iso_dio_decode
  import iso_dio_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h300
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd,
  input  logic                wr,
  output logic                in_win,
  output logic [WIN_SIZE-1:0] rd_hit,
  output logic [WIN_SIZE-1:0] wr_hit
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  logic [WIN_LOG2-1:0] ofs;

  assign in_win = (addr[ADDR_W-1:WIN_LOG2] == BASE_V[ADDR_W-1:WIN_LOG2]);
  assign ofs    = addr[WIN_LOG2-1:0];

  for (genvar i = 0; i < WIN_SIZE; i++) begin : g_hit
    assign rd_hit[i] = rd & in_win & (ofs == WIN_LOG2'(i));
    assign wr_hit[i] = wr & in_win & (ofs == WIN_LOG2'(i));
  end
endmodule

// File: rtl/iso_dio_out_latch.sv
module iso_dio_out_latch
  import iso_dio_pkg::*;
#(
  parameter int N_OUT = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_OUT/BYTE_W-1:0]  byte_we,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [N_OUT-1:0]         q
);
  localparam int NBYTES = N_OUT / BYTE_W;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] q_r, q_nxt;

    always_comb begin
      q_nxt = q_r;
      if (byte_we[b]) q_nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_r <= '1;
      else if (byte_we[b]) q_r <= q_nxt;
    end

    assign q[b*BYTE_W +: BYTE_W] = q_r;
  end
endmodule

// File: rtl/iso_dio_in_sync.sv
module iso_dio_in_sync #(
  parameter int N_IN   = 16,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] pins,
  output logic [N_IN-1:0] sync_q,
  output logic            change
);
  logic [N_IN-1:0] stage_q [STAGES];
  logic [N_IN-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N_IN-1:0] d;
    if (s == 0) begin : g_first
      assign d = pins;
    end else begin : g_next
      assign d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= d;
    end
  end

  assign sync_q = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q;
  end

  // any bit differing from the previous sample: both edge directions
  assign change = |(sync_q ^ prev_q);
endmodule

// File: rtl/iso_dio_irq_ctrl.sv
module iso_dio_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_set,
  input  logic en_clr,
  input  logic pend_clr,
  input  logic change,
  output logic en_q,
  output logic pend_q,
  output logic irq
);
  logic en_nxt, pend_nxt;

  always_comb begin
    en_nxt = en_q;
    if (en_clr)      en_nxt = 1'b0;
    else if (en_set) en_nxt = 1'b1;
  end

  // a new event in the clearing cycle keeps the flag set
  always_comb begin
    pend_nxt = pend_q;
    if (pend_clr)        pend_nxt = 1'b0;
    if (en_q && change)  pend_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign irq = en_q & pend_q;
endmodule

// File: rtl/iso_dio_port.sv
module iso_dio_port
  import iso_dio_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h300,
  parameter int N_OUT  = 16,
  parameter int N_IN   = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  input  logic [N_IN-1:0]   in_lines,
  output logic [N_OUT-1:0]  out_lines,
  output logic              irq
);
  localparam int OUT_BYTES = N_OUT / BYTE_W;
  localparam int IN_BYTES  = N_IN / BYTE_W;

  logic                in_win;
  logic [WIN_SIZE-1:0] rd_hit, wr_hit;
  logic [OUT_BYTES-1:0] out_we;
  logic [N_IN-1:0]     in_sync;
  logic                in_change;
  logic                irq_en_q, irq_pend_q;

  iso_dio_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .in_win(in_win), .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  for (genvar b = 0; b < OUT_BYTES; b++) begin : g_owe
    assign out_we[b] = wr_hit[out_ofs(b)];
  end

  iso_dio_out_latch #(.N_OUT(N_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .byte_we(out_we),
    .wdata(bus_wdata), .q(out_lines)
  );

  iso_dio_in_sync #(.N_IN(N_IN), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins(in_lines),
    .sync_q(in_sync), .change(in_change)
  );

  iso_dio_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_set(rd_hit[OFS_CTRL]), .en_clr(wr_hit[OFS_CTRL]),
    .pend_clr(wr_hit[OFS_IN_LO]), .change(in_change),
    .en_q(irq_en_q), .pend_q(irq_pend_q), .irq(irq)
  );

  // read-back: OR of byte sources gated by one-hot hits
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < OUT_BYTES; b++)
      if (rd_hit[out_ofs(b)]) bus_rdata = bus_rdata | out_lines[b*BYTE_W +: BYTE_W];
    for (int b = 0; b < IN_BYTES; b++)
      if (rd_hit[in_ofs(b)]) bus_rdata = bus_rdata | in_sync[b*BYTE_W +: BYTE_W];
  end

  logic unused_hits;
  assign unused_hits = ^{in_win, rd_hit[OFS_RSV3], rd_hit[OFS_RSV6], rd_hit[OFS_RSV7],
                         wr_hit[OFS_RSV3], wr_hit[OFS_RSV6], wr_hit[OFS_RSV7],
                         wr_hit[OFS_IN_HI], rd_hit[OFS_IN_LO]};
endmodule

// File: rtl/iso_dio_port_chk.sv
module iso_dio_port_chk #(
  parameter int ADDR_W = 10,
  parameter int BASE   = 'h300,
  parameter int N_OUT  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [N_OUT-1:0]  out_lines,
  input logic              irq,
  input logic              irq_en_q
);
  logic [ADDR_W-1:0] a_lo, a_hi;
  logic in_w;
  assign a_lo = ADDR_W'(BASE);
  assign a_hi = ADDR_W'(BASE + 7);
  assign in_w = (bus_addr >= a_lo) && (bus_addr <= a_hi);

  a_r2_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == a_lo) |=> (out_lines[7:0] == $past(bus_wdata)));
  a_r6_outside_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_w) |=> $stable(out_lines));
  a_r6_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
  a_r7_enable_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == a_lo + ADDR_W'(2)) |=> irq_en_q);
  a_r8_disable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == a_lo + ADDR_W'(2)) |=> !irq);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_wr) |=> irq);
  a_r1_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en_q);
endmodule

bind iso_dio_port iso_dio_port_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .out_lines(out_lines), .irq(irq), .irq_en_q(irq_en_q)
);

// File: tb/iso_dio_port_tb.sv
`timescale 1ns/1ps
module iso_dio_port_tb;
  localparam int ADDR_W = 10;
  localparam int BASE   = 'h300;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_rdata;
  logic [15:0]       in_lines = '0;
  logic [15:0]       out_lines;
  logic              irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_out = 16'hFFFF;
  logic [15:0] m_in  = 16'h0000;
  bit m_en = 0, m_pend = 0;

  always #5 clk = ~clk;

  iso_dio_port #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .in_lines(in_lines), .out_lines(out_lines), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(BASE) || a > ADDR_W'(BASE + 7)) return 8'h00;
    case (a[2:0])
      3'd0: return m_out[7:0];
      3'd4: return m_out[15:8];
      3'd1: return m_in[7:0];
      3'd5: return m_in[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit in_win(input logic [ADDR_W-1:0] a);
    return (a >= ADDR_W'(BASE)) && (a <= ADDR_W'(BASE + 7));
  endfunction

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (in_win(a)) begin
      case (a[2:0])
        3'd0: m_out[7:0]  = d;
        3'd4: m_out[15:8] = d;
        3'd1: m_pend = 0;
        3'd2: m_en = 0;
        default: ;
      endcase
    end
    chk(out_lines == m_out, "R2/R5/R6 outputs after write", out_lines, m_out);
    chk(irq == (m_en && m_pend), "R8/R10 irq after write", irq, m_en && m_pend);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a);
    logic [7:0] e;
    e = exp_read(a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(bus_rdata == e, "R3/R4/R5/R6 read data", bus_rdata, e);
    @(negedge clk);
    bus_rd = 1'b0;
    if (in_win(a) && a[2:0] == 3'd2) m_en = 1;
    #1;
    chk(bus_rdata == 8'h00, "R6 idle rdata", bus_rdata, 0);
    chk(irq == (m_en && m_pend), "R7 irq after read", irq, m_en && m_pend);
  endtask

  task automatic do_input(input logic [15:0] v);
    @(negedge clk);
    if (v != m_in && m_en) m_pend = 1;
    in_lines = v;
    m_in = v;
    repeat (3) @(negedge clk);
    chk(irq == (m_en && m_pend), "R9/R11 irq after input change", irq, m_en && m_pend);
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [ADDR_W-1:0] ra;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_lines == 16'hFFFF, "R1 reset outputs", out_lines, 16'hFFFF);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);

    // R2 byte independence
    do_write(ADDR_W'(BASE), 8'h5A);
    chk(out_lines == 16'hFF5A, "R2 low byte only", out_lines, 16'hFF5A);
    do_write(ADDR_W'(BASE + 4), 8'h3C);
    chk(out_lines == 16'h3C5A, "R2 high byte only", out_lines, 16'h3C5A);
    do_read(ADDR_W'(BASE));        // R3
    do_read(ADDR_W'(BASE + 4));    // R3

    // R4 synchroniser latency: not visible after one edge, visible after two
    @(negedge clk);
    in_lines = 16'hA51E; m_in = 16'hA51E;
    @(negedge clk);
    bus_addr = ADDR_W'(BASE + 1); bus_rd = 1'b1; #1;
    chk(bus_rdata == 8'h00, "R4 one edge latency", bus_rdata, 0);
    @(negedge clk); #1;
    chk(bus_rdata == 8'h1E, "R4 two edge latency", bus_rdata, 8'h1E);
    bus_rd = 1'b0;
    repeat (2) @(negedge clk);
    do_read(ADDR_W'(BASE + 5));

    // R5 reserved offsets
    do_write(ADDR_W'(BASE + 3), 8'h00);
    do_write(ADDR_W'(BASE + 6), 8'h11);
    do_write(ADDR_W'(BASE + 7), 8'h22);
    do_read(ADDR_W'(BASE + 3));
    do_read(ADDR_W'(BASE + 7));

    // R6 outside window
    do_write(ADDR_W'(BASE + 8), 8'h00);
    do_write(ADDR_W'(BASE - 8), 8'h00);
    do_read(ADDR_W'(BASE + 8));
    do_read(ADDR_W'(BASE - 4));

    // R11 change while disabled, then enable: no irq
    do_input(16'h0001);
    do_read(ADDR_W'(BASE + 2));
    chk(irq == 1'b0, "R11 no pending from disabled change", irq, 0);

    // R9 falling edge sets pending
    do_input(16'h0000);
    chk(irq == 1'b1, "R9 falling edge irq", irq, 1);
    // R10 sticky through more changes
    do_input(16'h8000);
    chk(irq == 1'b1, "R10 sticky", irq, 1);
    // R8 disable, R7 re-enable shows pending again
    do_write(ADDR_W'(BASE + 2), 8'hFF);
    chk(irq == 1'b0, "R8 disabled", irq, 0);
    do_read(ADDR_W'(BASE + 2));
    chk(irq == 1'b1, "R7 re-enable pending", irq, 1);
    // R10 clear with arbitrary data
    do_write(ADDR_W'(BASE + 1), 8'hA7);
    chk(irq == 1'b0, "R10 cleared", irq, 0);
    // R9 rising edge
    do_input(16'h8010);
    chk(irq == 1'b1, "R9 rising edge irq", irq, 1);
    do_write(ADDR_W'(BASE + 1), 8'h00);

    // R10 clear in same cycle as new change: set wins
    @(negedge clk);
    in_lines = 16'h0010; m_in = 16'h0010;
    @(negedge clk);
    @(negedge clk);
    bus_addr = ADDR_W'(BASE + 1); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    m_pend = 1;
    chk(irq == 1'b1, "R10 set beats clear", irq, 1);
    do_write(ADDR_W'(BASE + 1), 8'h00);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 6);
      ra = ADDR_W'(BASE) + ADDR_W'($urandom % 8);
      if ($urandom % 8 == 0) ra = ADDR_W'($urandom);
      case (op)
        0, 1: do_write(ra, 8'($urandom));
        2, 3: do_read(ra);
        default: do_input(($urandom % 2 == 0) ? m_in : 16'($urandom));
      endcase
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule